// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a read or write burst on a synchronous DRAM. A burst opens with a start strobe that carries the first column. The mode fields captured with that strobe fix the burst length and the beat ordering. From then on the block presents one column per clock until the burst ends.

Fixed-length bursts of 2, 4 or 8 beats stay inside an aligned group of that size. Within the group the order is either sequential, wrapping at the group edge, or interleaved, with the low bits XORed with the beat index. A full-page burst instead steps through the whole column field, wraps at the top column and runs until it is stopped. A stop strobe cuts any burst short. A fresh start strobe abandons the running burst and opens a new one.

The column width is a parameter: 9 bits suits a x16 organisation and 10 bits suits a x8 one.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first start, `beat_valid`, `last_beat` and `col` are all zero.
- R2: A start sampled at a rising edge makes `beat_valid` high in the next cycle, with `col` equal to the sampled `start_col`. That cycle is beat 0.
- R3: `burst_len` values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Any value with bit 2 set selects a full page. A fixed burst raises `last_beat` on its final beat and drops `beat_valid` in the cycle after.
- R4: In sequential order (`interleave` = 0) with length L, beat k has the start column's upper bits unchanged. Its low log2(L) bits are (start + k) mod L.
- R5: In interleaved order (`interleave` = 1) with length L, beat k is the start column with its low log2(L) bits XORed with k.
- R6: In full-page mode each beat is the previous column plus one, wrapping from 2^COL_W-1 to 0. `interleave` has no effect. `last_beat` stays low until a stop is taken.
- R7: A stop sampled while a beat is shown that is not the last makes the next beat the final one, flagged by `last_beat`. A stop while no burst runs leaves `beat_valid` low.
- R8: A start sampled during a burst abandons it and begins the new burst the next cycle. Start takes priority over a stop in the same cycle.
- R9: A length of 1 yields exactly one beat at the start column, with `last_beat` high on that beat.
- R10: `last_beat` is never high while `beat_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a burst at `start_col` |
| start_col | input | COL_W | First column of the burst |
| burst_len | input | 3 | Length code, sampled with start |
| interleave | input | 1 | 1 selects interleaved order, sampled with start |
| stop | input | 1 | Ends the running burst early |
| col | output | COL_W | Column for the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final one |

## Verification
Every output is registered. A start sampled at one edge therefore shows beat 0 one cycle later, each further beat follows one cycle after that, and a stop sampled at an edge marks the beat that appears one cycle later as the last. The bench drives inputs at the falling edge and keeps a cycle-level model clocked at the same rising edge, built from the ordering formulas. It compares the ports against that model at the next falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       burst_len,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat
);

  logic [COL_W-1:0] base_q, k_q, mask_q, start_mask, k_n, nxt;
  logic             full_q, il_q;

  always_comb begin
    start_mask = '0;
    case (burst_len)
      3'd1:    start_mask[0]   = 1'b1;
      3'd2:    start_mask[1:0] = 2'b11;
      3'd3:    start_mask[2:0] = 3'b111;
      default: start_mask = '0;
    endcase
  end

  assign k_n = k_q + 1'b1;
  assign nxt = full_q ? col + 1'b1 :
               il_q   ? (base_q ^ (k_n & mask_q)) :
                        ((base_q & ~mask_q) | ((base_q + k_n) & mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      k_q        <= '0;
      mask_q     <= '0;
      full_q     <= 1'b0;
      il_q       <= 1'b0;
      col        <= '0;
      beat_valid <= 1'b0;
      last_beat  <= 1'b0;
    end else if (start) begin
      base_q     <= start_col;
      k_q        <= '0;
      mask_q     <= start_mask;
      full_q     <= burst_len[2];
      il_q       <= interleave;
      col        <= start_col;
      beat_valid <= 1'b1;
      last_beat  <= (burst_len == 3'd0);
    end else if (beat_valid && !last_beat) begin
      k_q       <= k_n;
      col       <= nxt;
      last_beat <= stop || (!full_q && k_n == mask_q);
    end else begin
      beat_valid <= 1'b0;
      last_beat  <= 1'b0;
    end
  end

  // R10
  last_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col)));

  // R3
  ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  // R4
  upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start && !full_q) |=>
      ((col & ~mask_q) == ($past(col) & ~mask_q)));

  // R6
  full_page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start && full_q) |=> (col == $past(col) + 1'b1));

  // R7
  stop_marks_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start && stop) |=> (beat_valid && last_beat));

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  localparam int CLK_P = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, interleave = 1'b0, stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] burst_len = '0;
  logic [COL_W-1:0] col;
  logic beat_valid, last_beat;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .burst_len(burst_len), .interleave(interleave), .stop(stop),
    .col(col), .beat_valid(beat_valid), .last_beat(last_beat));

  always #(CLK_P/2) clk = ~clk;

  logic [COL_W-1:0] e_base, e_k;
  logic [2:0] e_bl;
  logic e_il, e_valid, e_last;

  function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] b, logic [COL_W-1:0] k,
                                               logic [2:0] bl, logic il);
    int len;
    logic [COL_W-1:0] low;
    if (bl[2]) return b + k;
    len = 1 << bl[1:0];
    low = COL_W'(len - 1);
    if (il) return b ^ (k & low);
    return (b & ~low) | COL_W'((int'(b & low) + int'(k)) % len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= 0; e_last <= 0; e_k <= '0; e_base <= '0; e_bl <= '0; e_il <= 0;
    end else if (start) begin
      e_base <= start_col; e_k <= '0; e_bl <= burst_len; e_il <= interleave;
      e_valid <= 1; e_last <= (burst_len == 3'd0);
    end else if (e_valid && !e_last) begin
      e_k <= e_k + 1'b1;
      e_last <= stop || (!e_bl[2] && int'(e_k) + 2 == (1 << e_bl[1:0]));
    end else begin
      e_valid <= 0; e_last <= 0;
    end
  end

  task automatic compare(string tag);
    logic [COL_W-1:0] ec;
    vectors++;
    ec = e_valid ? beat_col(e_base, e_k, e_bl, e_il) : '0;
    if (beat_valid !== e_valid || last_beat !== e_last) begin
      fails++;
      $display("FAIL %s valid/last actual=%b/%b expected=%b/%b", tag, beat_valid, last_beat, e_valid, e_last);
    end else if (e_valid && col !== ec) begin
      fails++;
      $display("FAIL %s col actual=%0d expected=%0d", tag, col, ec);
    end else if (last_beat && !beat_valid) begin
      fails++;
      $display("FAIL R10 last without valid actual=1 expected=0");
    end
  endtask

  task automatic cyc(bit s, int sc, int bl, bit il, bit sp, string tag);
    start = s; start_col = COL_W'(sc); burst_len = 3'(bl); interleave = il; stop = sp;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    vectors++;
    if (beat_valid !== 0 || last_beat !== 0 || col !== '0) begin
      fails++;
      $display("FAIL R1 reset actual=%b/%b/%0d expected=0/0/0", beat_valid, last_beat, col);
    end
    rst_n = 1;
    idle(2, "R1");
    cyc(1, 5, 0, 0, 0, "R2"); idle(2, "R9");
    cyc(1, 13, 3, 0, 0, "R2"); idle(8, "R4");
    cyc(1, 1021, 2, 0, 0, "R4"); idle(4, "R3");
    cyc(1, 6, 2, 1, 0, "R5"); idle(4, "R5");
    cyc(1, 9, 3, 1, 0, "R5"); idle(8, "R5");
    cyc(1, 1022, 7, 1, 0, "R6"); idle(4, "R6");
    cyc(0, 0, 0, 0, 1, "R7"); idle(2, "R7");
    cyc(0, 0, 0, 0, 1, "R7"); cyc(0, 0, 0, 0, 1, "R7");
    cyc(1, 40, 3, 0, 0, "R2"); idle(2, "R8");
    cyc(1, 100, 2, 1, 1, "R8"); idle(5, "R8");
    cyc(1, 200, 1, 0, 0, "R3"); idle(3, "R3");
    cyc(1, 300, 5, 0, 0, "R6"); idle(3, "R6");
    cyc(0, 0, 0, 0, 1, "R7"); idle(2, "R7");
    void'($urandom(1234));
    for (int i = 0; i < 4000; i++) begin
      bit s = ($urandom % (e_valid ? 8 : 3)) == 0;
      int bl = $urandom % 8;
      bit il = $urandom % 2;
      string tag = !s ? (e_bl[2] ? "R6" : (e_il ? "R5" : "R4")) : "R8";
      cyc(s, $urandom % 1024, bl, il, ($urandom % 10) == 0, tag);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule